// File: doc/BRIEF.md
# Boot Window Command Sequencer

This block watches host writes that land in the boot-buffer address window of a NAND-type flash device and turns them into actions. A write is decoded as a command word when its word offset falls in the low window (0x0000 to 0x01FF) or the high window (0x8000 to 0x800F). Writes to any other offset are ignored. The block recognises three commands:

- **Warm reset.** Asks the rest of the device to reset.
- **Identification.** Fills the first three words of the boot buffer with identity bytes.
- **Load.** An armed two-write sequence that starts a full-page load into data buffer 0 and then moves the page address on by one page.

The block owns the 8-bit page address register, which the host can also write through a dedicated port. The block address comes in from outside as a 12-bit block number plus an upper-die select. The sector number is built from both registers. The array read and the buffer memory belong to neighbouring blocks, which receive the request pulses and the boot-buffer write strobes from this one.

The controller has four states:

| State | Meaning | Transitions |
|---|---|---|
| IDLE | Waiting for a first command | Warm reset stays in IDLE. Identification goes to ID_DEV. The arm command goes to ARMED. |
| ARMED | Waiting for the second write | Any window write returns to IDLE and starts a load only if it is 0x0000. Writes outside the window leave the state unchanged. |
| ID_DEV | Writing the device byte | Always moves to ID_WP. |
| ID_WP | Writing the protection byte | Always returns to IDLE. |

Top module: `boot_cmd_seq`

## Requirements
- R1: A write is decoded only when wr_addr is in 0x0000..0x01FF or 0x8000..0x800F. A write at any other offset changes no output, no state and no page register.
- R2: In IDLE, a window write of 0x00F0 raises warm_rst_req for exactly one cycle, one cycle after the write, and clears page_addr to 0x00.
- R3: In IDLE, a window write of 0x00E0 arms the sequence. The next window write of 0x0000 raises load_req for one cycle, one cycle after that write. Writes outside the window in between keep the sequence armed.
- R4: When armed, a window write of any value other than 0x0000 disarms the sequence without a load, a reset or a buffer write.
- R5: load_sector = page[1:0] + ((page[7:2] + (eff << 6)) << 2). Here eff = blk_num, ORed with DENS_MASK (default 0x1000) when blk_upper is 1. page is the page register value before the load.
- R6: When a load starts, page_addr becomes (page_addr + 4) mod 256 in the same cycle that load_req rises.
- R7: In IDLE, a window write of 0x0090 produces three consecutive boot-buffer writes with bbuf_we high. They are index 0 with {8'h00, mfr_id}, then index 1 with {8'h00, dev_id}, then index 2 with {8'h00, wp_low}. bbuf_we then falls.
- R8: In IDLE, a window write of any other value (including 0x0000) has no effect.
- R9: While busy is high (states ID_DEV and ID_WP), window writes are ignored. At most one of warm_rst_req, load_req and bbuf_we is high in any cycle.
- R10: load_count always reads 4.
- R11: After reset the block is in IDLE with every strobe low, busy low and page_addr 0x00.
- R12: page_we loads page_wdata into page_addr on the next clock. If page_we coincides with a load start, the load's advance wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 16 | Host write word offset |
| wr_data | input | 16 | Host write data (command word) |
| blk_num | input | 12 | Block number field of the block address |
| blk_upper | input | 1 | Upper-die select; ORs DENS_MASK into the block |
| page_we | input | 1 | Page register write strobe |
| page_wdata | input | 8 | Page register write value |
| mfr_id | input | 8 | Manufacturer identity byte |
| dev_id | input | 8 | Device identity byte |
| wp_low | input | 8 | Low byte of write-protect status |
| page_addr | output | 8 | Page address register |
| busy | output | 1 | Identification sequence in progress |
| warm_rst_req | output | 1 | One-cycle warm reset request |
| load_req | output | 1 | One-cycle page load request |
| load_sector | output | EBLK_W+8 | Sector number for the load |
| load_count | output | 3 | Sectors per load (fixed 4) |
| bbuf_we | output | 1 | Boot-buffer write strobe |
| bbuf_idx | output | 2 | Boot-buffer word index |
| bbuf_wdata | output | 16 | Boot-buffer write data |

## Verification
The assertions assume that the host issues no write while reset is asserted. They also assume that blk_num and blk_upper are steady in the cycle a load starts. The assertions compare request pulses against the page register one cycle earlier, so this condition matters for them. The bench changes the block inputs only while the sequencer is idle. It drives one host write at a time on the falling clock edge and holds page_we low except in the one test that targets the advance-over-write priority.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
    localparam int PG_W = 8;
    localparam int WORD_W = 16;
    localparam logic [WORD_W-1:0] CMD_WARM_RST = 16'h00F0;
    localparam logic [WORD_W-1:0] CMD_READ_ID  = 16'h0090;
    localparam logic [WORD_W-1:0] CMD_LOAD_ARM = 16'h00E0;
    localparam logic [WORD_W-1:0] CMD_LOAD_GO  = 16'h0000;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_ID_DEV = 2'd2,
        ST_ID_WP  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/boot_win_decode.sv
module boot_win_decode #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] LO_BASE = 16'h0000,
    parameter logic [ADDR_W-1:0] LO_LAST = 16'h01FF,
    parameter logic [ADDR_W-1:0] HI_BASE = 16'h8000,
    parameter logic [ADDR_W-1:0] HI_LAST = 16'h800F
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              hit
);
    logic in_lo;
    logic in_hi;

    generate
        if (LO_BASE == '0) begin : g_lo_zero
            assign in_lo = (wr_addr <= LO_LAST);
        end else begin : g_lo_range
            assign in_lo = (wr_addr >= LO_BASE) && (wr_addr <= LO_LAST);
        end
    endgenerate

    assign in_hi = (wr_addr >= HI_BASE) && (wr_addr <= HI_LAST);
    assign hit   = wr_en && (in_lo || in_hi);
endmodule

// File: rtl/boot_sector_calc.sv
module boot_sector_calc #(
    parameter int BLK_W  = 12,
    parameter int EBLK_W = 14,
    parameter logic [EBLK_W-1:0] DENS_MASK = 14'h1000,
    localparam int SEC_W = EBLK_W + 8
) (
    input  logic [7:0]       page,
    input  logic [BLK_W-1:0] blk_num,
    input  logic             blk_upper,
    output logic [SEC_W-1:0] sector
);
    logic [EBLK_W-1:0] eff_blk;
    logic [EBLK_W+5:0] inner;

    always_comb begin
        eff_blk = {{(EBLK_W-BLK_W){1'b0}}, blk_num};
        if (blk_upper) begin
            eff_blk = eff_blk | DENS_MASK;
        end
        inner  = (EBLK_W+6)'(page[7:2]) + {eff_blk, 6'b0};
        sector = SEC_W'(page[1:0]) + {inner, 2'b00};
    end
endmodule

// File: rtl/boot_page_reg.sv
module boot_page_reg #(
    parameter int PG_W = 8,
    parameter int STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            step,
    input  logic            we,
    input  logic [PG_W-1:0] wdata,
    output logic [PG_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (step) begin
            q <= q + PG_W'(STEP);
        end else if (we) begin
            q <= wdata;
        end
    end

    // R6: a page advance adds one page and wraps
    p_page_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> (q == PG_W'($past(q) + PG_W'(STEP))));

    // R2: a warm reset clears the page register
    p_page_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));
endmodule

// File: rtl/boot_cmd_seq.sv
module boot_cmd_seq
    import boot_seq_pkg::*;
#(
    parameter int BLK_W  = 12,
    parameter int EBLK_W = 14,
    parameter logic [EBLK_W-1:0] DENS_MASK = 14'h1000,
    parameter int SECT_PER_LOAD = 4,
    localparam int SEC_W = EBLK_W + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [BLK_W-1:0]  blk_num,
    input  logic              blk_upper,
    input  logic              page_we,
    input  logic [7:0]        page_wdata,
    input  logic [7:0]        mfr_id,
    input  logic [7:0]        dev_id,
    input  logic [7:0]        wp_low,
    output logic [7:0]        page_addr,
    output logic              busy,
    output logic              warm_rst_req,
    output logic              load_req,
    output logic [SEC_W-1:0]  load_sector,
    output logic [2:0]        load_count,
    output logic              bbuf_we,
    output logic [1:0]        bbuf_idx,
    output logic [15:0]       bbuf_wdata
);
    seq_state_t state;
    seq_state_t state_nx;
    logic       hit;
    logic       go_rst;
    logic       go_id;
    logic       go_load;
    logic [SEC_W-1:0] sec_now;

    boot_win_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .hit     (hit)
    );

    boot_sector_calc #(
        .BLK_W     (BLK_W),
        .EBLK_W    (EBLK_W),
        .DENS_MASK (DENS_MASK)
    ) u_sec (
        .page      (page_addr),
        .blk_num   (blk_num),
        .blk_upper (blk_upper),
        .sector    (sec_now)
    );

    boot_page_reg #(
        .PG_W (PG_W),
        .STEP (SECT_PER_LOAD)
    ) u_page (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (go_rst),
        .step  (go_load),
        .we    (page_we),
        .wdata (page_wdata),
        .q     (page_addr)
    );

    assign go_rst  = (state == ST_IDLE)  && hit && (wr_data == CMD_WARM_RST);
    assign go_id   = (state == ST_IDLE)  && hit && (wr_data == CMD_READ_ID);
    assign go_load = (state == ST_ARMED) && hit && (wr_data == CMD_LOAD_GO);
    assign busy    = (state == ST_ID_DEV) || (state == ST_ID_WP);
    assign load_count = 3'(SECT_PER_LOAD);

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (hit) begin
                    if (wr_data == CMD_READ_ID) begin
                        state_nx = ST_ID_DEV;
                    end else if (wr_data == CMD_LOAD_ARM) begin
                        state_nx = ST_ARMED;
                    end
                end
            end
            ST_ARMED: begin
                if (hit) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_ID_DEV: state_nx = ST_ID_WP;
            ST_ID_WP:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_rst_req <= 1'b0;
            load_req     <= 1'b0;
            load_sector  <= '0;
            bbuf_we      <= 1'b0;
            bbuf_idx     <= 2'd0;
            bbuf_wdata   <= 16'h0000;
        end else begin
            warm_rst_req <= 1'b0;
            load_req     <= 1'b0;
            bbuf_we      <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (go_rst) begin
                        warm_rst_req <= 1'b1;
                    end
                    if (go_id) begin
                        bbuf_we    <= 1'b1;
                        bbuf_idx   <= 2'd0;
                        bbuf_wdata <= {8'h00, mfr_id};
                    end
                end
                ST_ARMED: begin
                    if (go_load) begin
                        load_req    <= 1'b1;
                        load_sector <= sec_now;
                    end
                end
                ST_ID_DEV: begin
                    bbuf_we    <= 1'b1;
                    bbuf_idx   <= 2'd1;
                    bbuf_wdata <= {8'h00, dev_id};
                end
                ST_ID_WP: begin
                    bbuf_we    <= 1'b1;
                    bbuf_idx   <= 2'd2;
                    bbuf_wdata <= {8'h00, wp_low};
                end
            endcase
        end
    end

    // R2: reset request is a single-cycle pulse
    p_rst_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_req |=> !warm_rst_req);

    // R10: load request is a single-cycle pulse with a fixed count
    p_load_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> !load_req);

    // R3: a load only follows the armed state
    p_load_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |-> ($past(state) == ST_ARMED));

    // R6: the page moves one page on with the load pulse
    p_load_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |-> (page_addr == 8'($past(page_addr) + 8'd4)));

    // R7: identification words come out in order 0, 1, 2
    p_id_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bbuf_we && bbuf_idx == 2'd0) |=> (bbuf_we && bbuf_idx == 2'd1));
    p_id_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bbuf_we && bbuf_idx == 2'd1) |=> (bbuf_we && bbuf_idx == 2'd2));
    p_id_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bbuf_we && bbuf_idx == 2'd2) |=> !bbuf_we);

    // R9: at most one action per cycle; busy blocks requests
    p_one_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({warm_rst_req, load_req, bbuf_we}));
    p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!warm_rst_req && !load_req));
endmodule

// File: tb/sim_boot_cmd_seq.sv
`timescale 1ns/1ps
module sim_boot_cmd_seq;
    localparam int SEC_W = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [11:0] blk_num = '0;
    logic blk_upper = 1'b0;
    logic page_we = 1'b0;
    logic [7:0] page_wdata = '0;
    logic [7:0] mfr_id = 8'hEC;
    logic [7:0] dev_id = 8'h36;
    logic [7:0] wp_low = 8'h02;
    logic [7:0] page_addr;
    logic busy, warm_rst_req, load_req, bbuf_we;
    logic [SEC_W-1:0] load_sector;
    logic [2:0] load_count;
    logic [1:0] bbuf_idx;
    logic [15:0] bbuf_wdata;

    int n_chk = 0;
    int n_bad = 0;
    int m_page = 0;

    always #2.5 clk = ~clk;

    boot_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .blk_num(blk_num), .blk_upper(blk_upper),
        .page_we(page_we), .page_wdata(page_wdata), .mfr_id(mfr_id),
        .dev_id(dev_id), .wp_low(wp_low), .page_addr(page_addr),
        .busy(busy), .warm_rst_req(warm_rst_req), .load_req(load_req),
        .load_sector(load_sector), .load_count(load_count),
        .bbuf_we(bbuf_we), .bbuf_idx(bbuf_idx), .bbuf_wdata(bbuf_wdata)
    );

    // {addr, data, kind}: kind 0 none, 1 warm reset, 2 load, 3 identification
    localparam logic [33:0] VEC [16] = '{
        {16'h0000, 16'h00F0, 2'd1},
        {16'h0010, 16'h00E0, 2'd0},
        {16'h8003, 16'h0000, 2'd2},
        {16'h01FF, 16'h00E0, 2'd0},
        {16'h800F, 16'h0000, 2'd2},
        {16'h0000, 16'h00E0, 2'd0},
        {16'h0001, 16'h1234, 2'd0},
        {16'h0002, 16'h0000, 2'd0},
        {16'h8010, 16'h00F0, 2'd0},
        {16'h0200, 16'h0090, 2'd0},
        {16'h0100, 16'h0090, 2'd3},
        {16'h0000, 16'h0055, 2'd0},
        {16'h0004, 16'h00E0, 2'd0},
        {16'h7FFF, 16'h0000, 2'd0},
        {16'h8000, 16'h0000, 2'd2},
        {16'h0000, 16'h00F0, 2'd1}
    };

    function automatic int exp_sector(int pg, int blk, bit up);
        int eff;
        eff = blk | (up ? 32'h1000 : 0);
        return (pg & 3) + ((((pg >> 2) & 63) + (eff << 6)) << 2);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // one host write; returns at the falling edge after the capturing edge
    task automatic host_wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_quiet(input string tag);
        check({tag, " strobes"}, {29'd0, warm_rst_req, load_req, bbuf_we}, 0);
        check({tag, " page"}, page_addr, m_page);
    endtask

    task automatic check_id(input string tag);
        check({tag, " id0"}, {bbuf_we, bbuf_idx, bbuf_wdata}, {1'b1, 2'd0, 8'h00, mfr_id});
        @(negedge clk);
        check({tag, " id1"}, {bbuf_we, bbuf_idx, bbuf_wdata}, {1'b1, 2'd1, 8'h00, dev_id});
        @(negedge clk);
        check({tag, " id2"}, {bbuf_we, bbuf_idx, bbuf_wdata}, {1'b1, 2'd2, 8'h00, wp_low});
        @(negedge clk);
        check({tag, " id end"}, bbuf_we, 0);
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 strobes", {29'd0, warm_rst_req, load_req, bbuf_we}, 0);
        check("R11 page/busy", {busy, page_addr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 load_count", load_count, 4);

        blk_num = 12'h005; blk_upper = 1'b1;
        for (int k = 0; k < 16; k++) begin
            logic [15:0] a, d;
            logic [1:0] kind;
            {a, d, kind} = VEC[k];
            host_wr(a, d);
            case (kind)
                2'd1: begin
                    m_page = 0;
                    check($sformatf("R2 vec%0d rst", k), warm_rst_req, 1);
                    check($sformatf("R2 vec%0d page", k), page_addr, 0);
                end
                2'd2: begin
                    check($sformatf("R3 vec%0d load", k), load_req, 1);
                    check($sformatf("R5 vec%0d sector", k), load_sector,
                          exp_sector(m_page, 12'h005, 1'b1));
                    m_page = (m_page + 4) & 255;
                    check($sformatf("R6 vec%0d page", k), page_addr, m_page);
                end
                2'd3: check_id($sformatf("R7 vec%0d", k));
                default: check_quiet($sformatf("R1/R4/R8 vec%0d", k));
            endcase
        end

        // R12: page write port, then wrap case with the lower die
        @(negedge clk);
        page_we = 1'b1; page_wdata = 8'hFE;
        @(negedge clk);
        page_we = 1'b0;
        m_page = 8'hFE;
        check("R12 page write", page_addr, 8'hFE);
        blk_upper = 1'b0; blk_num = 12'hFFF;
        host_wr(16'h0000, 16'h00E0);
        host_wr(16'h0008, 16'h0000);
        check("R5 sector lower die", load_sector, exp_sector(8'hFE, 12'hFFF, 1'b0));
        check("R6 page wrap", page_addr, 8'h02);
        check("R10 count", load_count, 4);
        @(negedge clk);
        check("R10 one-cycle pulse", load_req, 0);

        // R12: advance wins over a simultaneous page write
        host_wr(16'h0000, 16'h00E0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 16'h0000; wr_data = 16'h0000;
        page_we = 1'b1; page_wdata = 8'h33;
        @(negedge clk);
        wr_en = 1'b0; page_we = 1'b0;
        check("R12 advance priority", page_addr, 8'h06);
        m_page = 6;

        // R9: writes during the identification run are ignored
        host_wr(16'h0000, 16'h0090);
        check("R9 busy", busy, 1);
        wr_en = 1'b1; wr_addr = 16'h0000; wr_data = 16'h00F0;
        @(negedge clk);
        wr_en = 1'b0;
        check("R9 no reset when busy", warm_rst_req, 0);
        check("R9 id continues", {bbuf_we, bbuf_idx}, {1'b1, 2'd1});
        @(negedge clk);
        @(negedge clk);
        check("R9 page untouched", page_addr, m_page);
        check("R9 idle again", busy, 0);
        // the ignored reset must not have armed or acted afterwards
        host_wr(16'h0000, 16'h0000);
        check_quiet("R8 after busy");

        finish_run();
    end
endmodule